// File: doc/BRIEF.md
# Programmable Chip-Select Decoder

This block turns each bus cycle's address and function code into a chip-select number. It has four channels. Each channel holds a 32-bit base word and a 32-bit mask word, which are written and read back over a small register port. When an address strobe is present, every channel compares the address and the function code against its own base word. The mask word marks which bits are don't-care for that comparison.

The lowest-numbered channel that matches wins. The result is registered one cycle after the strobe and is presented two ways: as a code (channel index plus one, or zero for no match) and as one-hot select lines. Until channel 0 has been marked valid, every access is steered to select code 1. A processor can therefore fetch its boot code before any decode setting exists.

Top module: `chipsel_decoder`

## Requirements
- R1: After a synchronous active-low reset, all eight registers read back as zero and both the select code and the one-hot select lines are zero.
- R2: Register index 0 to 3 addresses the base word of channels 0 to 3, and index 4 to 7 addresses their mask words. A write stores the whole 32-bit data word. The readback output shows the indexed register combinationally.
- R3: While bit 0 of channel 0's base word is clear, every strobed access yields select code 1 with one-hot value 4'b0001, whatever the address and function code.
- R4: A channel whose base word bit 0 is clear never matches.
- R5: Address bits 31..8 are compared with base bits 31..8, except where mask bits 31..8 are set. Address bits 7..0 never affect the result.
- R6: The 4-bit function code is compared with base bits 7..4, except where mask bits 7..4 are set.
- R7: When several channels match, the lowest-numbered one wins. The code is the channel index plus one, and one-hot bit i goes high for channel i.
- R8: When channel 0 is valid and no channel matches, the code is 0 and no one-hot line is high.
- R9: The outputs are registered. The result for a strobed cycle appears after the next clock edge. A cycle without the strobe yields code 0 and all one-hot lines low after that edge.
- R10: A register write made in the same cycle as a strobed access does not affect that access. It is used from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index for write and readback |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Combinational readback of the indexed register |
| addr_valid | input | 1 | Address strobe for the current bus cycle |
| addr | input | 32 | Bus address |
| fc | input | 4 | Bus function code |
| sel_code | output | 3 | Registered select code, 0 = none, n = channel n-1 |
| sel_onehot | output | 4 | Registered one-hot select lines, bit i = channel i |

## Verification
The bench builds the block with its default parameters: four channels, 32-bit address, 4-bit function code and 8 always-ignored low address bits. With these values a single directed program can create an overlap between channel 1 and channel 3. It can also make channel 2 ignore only the two low function-code bits and give channel 0 a 1 MiB window. Priority, partial function-code masking, the boot fallback and its return when channel 0 is invalidated all fall within a few hundred cycles.

// File: rtl/chipsel_pkg.sv
// Package: field positions shared by the chip-select decoder modules.
// Assumes the base/mask word layout: valid flag at bit 0, function-code
// field in bits 7..4, compared address bits from ADDR_LO upward.
package chipsel_pkg;
    localparam int VALID_BIT = 0;
    localparam int FC_LO     = 4;
    localparam int ADDR_LO   = 8;
endpackage

// File: rtl/chipsel_regs.sv
// Module: chipsel_regs
// Holds the base and mask word of each channel. Index 0..NCH-1 selects a
// base word, NCH..2*NCH-1 a mask word. Readback is combinational. Only the
// decode fields are exported so downstream logic sees no unused bits.
// Assumes a synchronous active-low reset.
module chipsel_regs #(
    parameter int NCH   = 4,
    parameter int AW    = 32,
    parameter int FCW   = 4,
    parameter int IDX_W = $clog2(2 * NCH)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              reg_idx,
    input  logic [AW-1:0]                 wr_data,
    output logic [AW-1:0]                 rd_data,
    output logic [NCH-1:0]                ch_valid,
    output logic [NCH-1:0][AW-chipsel_pkg::ADDR_LO-1:0] base_addr,
    output logic [NCH-1:0][AW-chipsel_pkg::ADDR_LO-1:0] mask_addr,
    output logic [NCH-1:0][FCW-1:0]       base_fc,
    output logic [NCH-1:0][FCW-1:0]       mask_fc
);
    import chipsel_pkg::*;

    logic [NCH-1:0][AW-1:0] base_q;
    logic [NCH-1:0][AW-1:0] mask_q;

    // Store a write into the indexed base or mask word; clear all on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            mask_q <= '0;
        end else if (wr_en) begin
            for (int c = 0; c < NCH; c++) begin
                if (reg_idx == IDX_W'(c))       base_q[c] <= wr_data;
                if (reg_idx == IDX_W'(NCH + c)) mask_q[c] <= wr_data;
            end
        end
    end

    // Present the indexed register on the readback port.
    always_comb begin
        rd_data = '0;
        for (int c = 0; c < NCH; c++) begin
            if (reg_idx == IDX_W'(c))       rd_data = base_q[c];
            if (reg_idx == IDX_W'(NCH + c)) rd_data = mask_q[c];
        end
    end

    // Split each word into the fields the comparators need.
    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            ch_valid[c]  = base_q[c][VALID_BIT];
            base_addr[c] = base_q[c][AW-1:ADDR_LO];
            mask_addr[c] = mask_q[c][AW-1:ADDR_LO];
            base_fc[c]   = base_q[c][FC_LO+FCW-1:FC_LO];
            mask_fc[c]   = mask_q[c][FC_LO+FCW-1:FC_LO];
        end
    end

    // R2
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en) && ($past(reg_idx) < IDX_W'(NCH)))
            |-> (base_q[$past(reg_idx)] == $past(wr_data)));
endmodule

// File: rtl/chipsel_match.sv
// Module: chipsel_match
// Compares one channel's base fields with the bus address and function
// code. Set mask bits are don't-care on both sides. The low ADDR_LO address
// bits are always don't-care. An invalid channel never hits.
module chipsel_match #(
    parameter int AW  = 32,
    parameter int FCW = 4
) (
    input  logic                             valid,
    input  logic [AW-chipsel_pkg::ADDR_LO-1:0] base_addr,
    input  logic [AW-chipsel_pkg::ADDR_LO-1:0] mask_addr,
    input  logic [FCW-1:0]                   base_fc,
    input  logic [FCW-1:0]                   mask_fc,
    input  logic [AW-1:0]                    addr,
    input  logic [FCW-1:0]                   fc,
    output logic                             hit
);
    import chipsel_pkg::*;

    logic [AW-1:0] full_base;
    logic [AW-1:0] full_mask;
    logic          addr_ok;
    logic          fc_ok;

    // Widen the fields so low address bits become forced don't-care.
    always_comb begin
        full_base = {base_addr, {ADDR_LO{1'b0}}};
        full_mask = {mask_addr, {ADDR_LO{1'b1}}};
        addr_ok   = (((addr ^ full_base) & ~full_mask) == '0);
        fc_ok     = (((fc ^ base_fc) & ~mask_fc) == '0);
        hit       = valid && addr_ok && fc_ok;
    end
endmodule

// File: rtl/chipsel_prio.sv
// Module: chipsel_prio
// Picks the lowest-numbered hitting channel and encodes it both as
// index+1 and one-hot. While channel 0 is invalid it forces code 1.
module chipsel_prio #(
    parameter int NCH    = 4,
    parameter int CODE_W = $clog2(NCH + 1)
) (
    input  logic [NCH-1:0]    hits,
    input  logic              boot,
    output logic [CODE_W-1:0] code,
    output logic [NCH-1:0]    onehot
);
    // Scan from the highest channel down so the lowest hit is left in place.
    always_comb begin
        code   = '0;
        onehot = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (hits[i]) begin
                code      = CODE_W'(i + 1);
                onehot    = '0;
                onehot[i] = 1'b1;
            end
        end
        if (boot) begin
            code      = CODE_W'(1);
            onehot    = '0;
            onehot[0] = 1'b1;
        end
    end
endmodule

// File: rtl/chipsel_decoder.sv
// Module: chipsel_decoder (top)
// Programmable chip-select decoder. It has NCH channels of base/mask
// registers, parallel comparators, a priority encoder and registered select
// outputs. Register changes are seen by the decode from the next cycle.
// Assumes a synchronous active-low reset.
module chipsel_decoder #(
    parameter int NCH    = 4,
    parameter int AW     = 32,
    parameter int FCW    = 4,
    parameter int IDX_W  = $clog2(2 * NCH),
    parameter int CODE_W = $clog2(NCH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [AW-1:0]     wr_data,
    output logic [AW-1:0]     rd_data,
    input  logic              addr_valid,
    input  logic [AW-1:0]     addr,
    input  logic [FCW-1:0]    fc,
    output logic [CODE_W-1:0] sel_code,
    output logic [NCH-1:0]    sel_onehot
);
    import chipsel_pkg::*;
    localparam int FAW = AW - ADDR_LO;

    logic [NCH-1:0]           ch_valid;
    logic [NCH-1:0][FAW-1:0]  base_addr;
    logic [NCH-1:0][FAW-1:0]  mask_addr;
    logic [NCH-1:0][FCW-1:0]  base_fc;
    logic [NCH-1:0][FCW-1:0]  mask_fc;
    logic [NCH-1:0]           hits;
    logic [CODE_W-1:0]        code_d;
    logic [NCH-1:0]           onehot_d;

    chipsel_regs #(.NCH(NCH), .AW(AW), .FCW(FCW), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_idx(reg_idx),
        .wr_data(wr_data), .rd_data(rd_data), .ch_valid(ch_valid),
        .base_addr(base_addr), .mask_addr(mask_addr),
        .base_fc(base_fc), .mask_fc(mask_fc)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        chipsel_match #(.AW(AW), .FCW(FCW)) u_match (
            .valid(ch_valid[g]), .base_addr(base_addr[g]),
            .mask_addr(mask_addr[g]), .base_fc(base_fc[g]),
            .mask_fc(mask_fc[g]), .addr(addr), .fc(fc), .hit(hits[g])
        );
    end

    chipsel_prio #(.NCH(NCH), .CODE_W(CODE_W)) u_prio (
        .hits(hits), .boot(!ch_valid[0]), .code(code_d), .onehot(onehot_d)
    );

    // Capture the decode for strobed cycles; idle otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !addr_valid) begin
            sel_code   <= '0;
            sel_onehot <= '0;
        end else begin
            sel_code   <= code_d;
            sel_onehot <= onehot_d;
        end
    end

    // R9
    idle_after_nostrobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(addr_valid) |-> (sel_code == '0 && sel_onehot == '0));

    // R3
    boot_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(addr_valid) && !$past(ch_valid[0])) |-> (sel_code == CODE_W'(1)));

    // R7
    onehot_code_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_onehot) && ((sel_code == '0) == (sel_onehot == '0)));

    // R8
    no_hit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(addr_valid) && $past(ch_valid[0]) && ($past(hits) == '0))
            |-> (sel_code == '0));

    // R4
    invalid_never_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((hits & ~ch_valid) == '0));
endmodule

// File: tb/tb_chipsel_decoder.sv
module tb_chipsel_decoder;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [2:0]  reg_idx;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic        addr_valid;
    logic [31:0] addr;
    logic [3:0]  fc;
    logic [2:0]  sel_code;
    logic [3:0]  sel_onehot;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    chipsel_decoder dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_idx(reg_idx),
        .wr_data(wr_data), .rd_data(rd_data), .addr_valid(addr_valid),
        .addr(addr), .fc(fc), .sel_code(sel_code), .sel_onehot(sel_onehot)
    );

    function automatic logic [3:0] oh_of(input logic [2:0] c);
        return (c == 0) ? 4'b0 : (4'b1 << (c - 1));
    endfunction

    task automatic chk_out(input logic [2:0] exp, input string tag);
        n_tests++;
        if (sel_code !== exp || sel_onehot !== oh_of(exp)) begin
            n_fail++;
            $display("FAIL %s: code=%0d onehot=%b expected code=%0d onehot=%b",
                     tag, sel_code, sel_onehot, exp, oh_of(exp));
        end
    endtask

    task automatic wr_reg(input logic [2:0] idx, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_idx = idx; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] idx, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_idx = idx;
        #1;
        n_tests++;
        if (rd_data !== exp) begin
            n_fail++;
            $display("FAIL %s: rd[%0d]=%h expected %h", tag, idx, rd_data, exp);
        end
    endtask

    task automatic probe(input logic [31:0] a, input logic [3:0] f,
                         input logic [2:0] exp, input string tag);
        @(negedge clk);
        addr_valid = 1'b1; addr = a; fc = f;
        @(posedge clk); #1;
        chk_out(exp, tag);
        @(negedge clk);
        addr_valid = 1'b0;
    endtask

    // R1: reset state
    task automatic t_reset();
        for (int i = 0; i < 8; i++) rd_chk(3'(i), 32'h0, "R1 reset readback");
        chk_out(3'd0, "R1 reset outputs");
    endtask

    // R3 boot fallback, R9 idle without strobe
    task automatic t_boot();
        probe(32'hDEAD_BE00, 4'hA, 3'd1, "R3 boot any address");
        probe(32'h0000_0004, 4'h0, 3'd1, "R3 boot other address");
        @(negedge clk); addr_valid = 1'b0; addr = 32'h0; fc = 4'h0;
        @(posedge clk); #1;
        chk_out(3'd0, "R9 no strobe gives idle");
    endtask

    // R2 program and read back; R10 write seen from next cycle
    task automatic t_program();
        wr_reg(3'd4, 32'h000F_FFF0);
        wr_reg(3'd1, 32'h0040_0051);
        wr_reg(3'd5, 32'h0000_FF00);
        wr_reg(3'd2, 32'h0080_0001);
        wr_reg(3'd6, 32'h000F_FF30);
        wr_reg(3'd3, 32'h0040_0001);
        wr_reg(3'd7, 32'h0000_FFF0);
        rd_chk(3'd1, 32'h0040_0051, "R2 readback base1");
        rd_chk(3'd6, 32'h000F_FF30, "R2 readback mask2");
        rd_chk(3'd7, 32'h0000_FFF0, "R2 readback mask3");
        // Write base0 valid in the same cycle as a strobe that misses ch0 window.
        @(negedge clk);
        wr_en = 1'b1; reg_idx = 3'd0; wr_data = 32'h0000_0001;
        addr_valid = 1'b1; addr = 32'h0010_0000; fc = 4'h6;
        @(posedge clk); #1;
        chk_out(3'd1, "R10 same-cycle write unseen");
        @(negedge clk);
        wr_en = 1'b0;
        @(posedge clk); #1;
        chk_out(3'd0, "R10 write seen next cycle");
        @(negedge clk);
        addr_valid = 1'b0;
        rd_chk(3'd0, 32'h0000_0001, "R2 readback base0");
    endtask

    // R5 R6 R7 R8 decode checks
    task automatic t_decode();
        probe(32'h000A_1234, 4'h6, 3'd1, "R5 ch0 window with masked bits");
        probe(32'h0010_0000, 4'h6, 3'd0, "R8 no channel matches");
        probe(32'h0040_00FF, 4'h5, 3'd2, "R7 ch1 beats ch3, R5 low bits ignored");
        probe(32'h0040_1200, 4'h2, 3'd4, "R6 ch1 fc mismatch, ch3 wins");
        probe(32'h0085_5500, 4'h6, 3'd0, "R6 ch2 fc upper bits differ");
        probe(32'h0085_5500, 4'h3, 3'd3, "R6 ch2 fc low bits masked");
        probe(32'h0041_0000, 4'h5, 3'd0, "R5 unmasked address bit differs");
    endtask

    // R4 invalid channel; R3 return to boot
    task automatic t_invalid();
        wr_reg(3'd3, 32'h0040_0000);
        probe(32'h0040_1200, 4'h2, 3'd0, "R4 cleared valid never matches");
        wr_reg(3'd0, 32'h0000_0000);
        probe(32'h0010_0000, 4'h6, 3'd1, "R3 boot again after ch0 invalid");
    endtask

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; reg_idx = '0; wr_data = '0;
        addr_valid = 1'b0; addr = '0; fc = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_boot();
        t_program();
        t_decode();
        t_invalid();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule